// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead-Time Insertion

This block controls one leg of an inverter bridge. It receives a command for the upper switch that is active high and a command for the lower switch that is active low. It also receives an enable that shuts the leg down when it is low. It drives two registered gate-enable outputs, one for each switch.

The commands arrive from another clock domain, so the block synchronises them first. It then decodes them into one of five requests: shut down, idle, upper only, lower only, or clash. A clash is both commands active at once. It never grants a clash; the leg is parked with both switches off instead. When either output goes low, a cycle counter starts. No output may come on until the counter has run out, so the bridge always sees a guaranteed off interval between the two switches. A shutdown, a clash, or a reset also restarts that interval. A request that arrives after the interval has already passed goes straight through, with only the pipeline latency.

Top module: `hbg_phase_ctl`

## Requirements
- R1: While `rst` is high, both outputs are low. After `rst` falls, no output rises until `DEAD_CYC` edges have passed since the last edge on which the synchronised inputs still held their reset value. With a single-side command held from the release, the first rise comes `DEAD_CYC+2` edges after the release.
- R2: `drv_en`, `hi_cmd` and `lo_cmd_n` each pass through two flip-flops before they are decoded, and the outputs are registered. A change that is not held back by the dead time reaches the outputs on the third rising edge after it is applied.
- R3: With `drv_en` = 0, both outputs go low three edges later and stay low, whatever the commands are.
- R4: With `drv_en` = 1, `hi_cmd` = 1 and `lo_cmd_n` = 0 (clash), both outputs are low.
- R5: With `drv_en` = 1, `hi_cmd` = 0 and `lo_cmd_n` = 1 (idle), both outputs are low.
- R6: With `drv_en` = 1, `hi_cmd` = 1 and `lo_cmd_n` = 1, `gate_hi` is driven high once the dead time has expired. With `drv_en` = 1, `hi_cmd` = 0 and `lo_cmd_n` = 0, `gate_lo` is driven high once the dead time has expired.
- R7: `gate_hi` and `gate_lo` are never high in the same cycle.
- R8: On the edge where an output falls, the dead time restarts. No output rises before `DEAD_CYC` further edges have passed. If the opposite side is requested at the same moment as the release, it rises exactly `DEAD_CYC` edges after the fall.
- R9: Every edge on which the decoder sees a shutdown or a clash restarts the dead time. When the leg recovers to a single-side request, the output rises `DEAD_CYC+2` edges after that request is applied.
- R10: If a new single-side request is applied G edges after the release of the other side, the new output rises max(3, `DEAD_CYC`+3−G) edges after it is applied.
- R11: An output that is high stays high for as long as its own single-side request persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drv_en | input | 1 | Leg enable; low forces both outputs off |
| hi_cmd | input | 1 | Upper-switch command, active high, asynchronous |
| lo_cmd_n | input | 1 | Lower-switch command, active low, asynchronous |
| gate_hi | output | 1 | Upper-switch gate enable, registered |
| gate_lo | output | 1 | Lower-switch gate enable, registered |

## Verification
Two internal faults are dangerous here: a timer that is reloaded with the wrong value, and a timer that misses a reload. Either one shows up as an output rise that comes one or more edges earlier or later than max(3, `DEAD_CYC`+3−G). That error appears on the very first transition after the fault. If the decoder is wrong, a clash or shutdown is passed as a drive request, and both outputs can be high in the same cycle three edges after the bad input. The bench runs a cycle-exact reference model of the requirements. It sweeps the release-to-request gap G, the clash length and the shutdown length across the whole dead-time window and beyond it. It also steps through all 64 ordered pairs of input codes and a long pseudo-random stream, and compares both outputs on every cycle.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Decoded request for one half-bridge leg
    typedef enum logic [2:0] {
        REQ_IDLE  = 3'd0,
        REQ_HIGH  = 3'd1,
        REQ_LOW   = 3'd2,
        REQ_CLASH = 3'd3,
        REQ_SHUT  = 3'd4
    } req_e;

    // Synchronised command word: enable, upper command, lower command (active low)
    typedef struct packed {
        logic en;
        logic hi;
        logic lo_n;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);
    localparam cmd_t CMD_RESET = '{en: 1'b0, hi: 1'b0, lo_n: 1'b1};

    // Gate-enable pair
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    localparam gate_t GATE_OFF = '{hi: 1'b0, lo: 1'b0};

    function automatic req_e decode_req(input cmd_t c);
        req_e r;
        if (!c.en)
            r = REQ_SHUT;
        else begin
            unique case ({c.hi, c.lo_n})
                2'b10:   r = REQ_CLASH;
                2'b01:   r = REQ_IDLE;
                2'b11:   r = REQ_HIGH;
                default: r = REQ_LOW;
            endcase
        end
        return r;
    endfunction

    // Counter width that can hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  cmd_t cmd,
    output req_e req
);

    always_comb req = decode_req(cmd);

endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 60
) (
    input  logic  clk,
    input  logic  rst,
    input  req_e  req,
    output gate_t gate
);

    localparam int            CW   = cnt_width(DEAD_CYC);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    gate_t         gate_q;
    logic [CW-1:0] cnt_q;
    logic          any_on;
    logic          expired;

    assign any_on  = gate_q.hi | gate_q.lo;
    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_OFF;
            cnt_q  <= LOAD;
        end else begin
            unique case (req)
                REQ_SHUT, REQ_CLASH: begin
                    gate_q <= GATE_OFF;
                    cnt_q  <= LOAD;
                end
                REQ_IDLE: begin
                    gate_q <= GATE_OFF;
                    if (any_on)        cnt_q <= LOAD;
                    else if (!expired) cnt_q <= cnt_q - ONE;
                end
                REQ_HIGH: begin
                    if (gate_q.lo) begin
                        gate_q <= GATE_OFF;
                        cnt_q  <= LOAD;
                    end else if (!gate_q.hi) begin
                        if (expired) gate_q.hi <= 1'b1;
                        else         cnt_q     <= cnt_q - ONE;
                    end
                end
                REQ_LOW: begin
                    if (gate_q.hi) begin
                        gate_q <= GATE_OFF;
                        cnt_q  <= LOAD;
                    end else if (!gate_q.lo) begin
                        if (expired) gate_q.lo <= 1'b1;
                        else         cnt_q     <= cnt_q - ONE;
                    end
                end
                default: begin
                    gate_q <= GATE_OFF;
                    cnt_q  <= LOAD;
                end
            endcase
        end
    end

    assign gate = gate_q;

endmodule

// File: rtl/hbg_phase_ctl.sv
module hbg_phase_ctl
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drv_en,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    output logic gate_hi,
    output logic gate_lo
);

    cmd_t  cmd_raw;
    cmd_t  cmd_s;
    req_e  req_w;
    gate_t gate_w;

    assign cmd_raw = '{en: drv_en, hi: hi_cmd, lo_n: lo_cmd_n};

    hbg_sync #(
        .WIDTH  (CMD_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CMD_RESET)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (cmd_raw),
        .q  (cmd_s)
    );

    hbg_decode u_decode (
        .cmd(cmd_s),
        .req(req_w)
    );

    hbg_deadtime #(
        .DEAD_CYC(DEAD_CYC)
    ) u_dead (
        .clk (clk),
        .rst (rst),
        .req (req_w),
        .gate(gate_w)
    );

    assign gate_hi = gate_w.hi;
    assign gate_lo = gate_w.lo;

endmodule

// File: rtl/hbg_phase_chk.sv
module hbg_phase_chk
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 60
) (
    input logic clk,
    input logic rst,
    input req_e req,
    input logic gate_hi,
    input logic gate_lo
);

    localparam int            GW  = cnt_width(DEAD_CYC) + 1;
    localparam logic [GW-1:0] LIM = GW'(DEAD_CYC);

    // Edges seen with both outputs low since the last high output or reset
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                     gap_q <= '0;
        else if (gate_hi || gate_lo) gap_q <= '0;
        else if (gap_q < LIM)        gap_q <= gap_q + GW'(1);
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo)); // R7

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi || gate_lo) |-> (gap_q >= LIM)); // R8

    AST_SHUT_OFF: assert property (@(posedge clk) disable iff (rst)
        (req == REQ_SHUT) |=> (!gate_hi && !gate_lo)); // R3

    AST_CLASH_OFF: assert property (@(posedge clk) disable iff (rst)
        (req == REQ_CLASH) |=> (!gate_hi && !gate_lo)); // R4

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
        (req == REQ_IDLE) |=> (!gate_hi && !gate_lo)); // R5

    AST_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
        (gate_hi && req == REQ_HIGH) |=> gate_hi); // R11

    AST_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
        (gate_lo && req == REQ_LOW) |=> gate_lo); // R11

    AST_HI_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> $past(req == REQ_HIGH)); // R6

    AST_LO_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> $past(req == REQ_LOW)); // R6

endmodule

bind hbg_phase_ctl hbg_phase_chk #(.DEAD_CYC(DEAD_CYC)) u_phase_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req_w),
    .gate_hi(gate_hi),
    .gate_lo(gate_lo)
);

// File: tb/test_hbg_phase_ctl.sv
module test_hbg_phase_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int DT         = 4;
    localparam int SETTLE     = 2 * DT + 8;

    // Input codes {drv_en, hi_cmd, lo_cmd_n}
    localparam logic [2:0] C_HIGH  = 3'b111;
    localparam logic [2:0] C_LOW   = 3'b100;
    localparam logic [2:0] C_IDLE  = 3'b101;
    localparam logic [2:0] C_CLASH = 3'b110;
    localparam logic [2:0] C_SHUT  = 3'b011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drv_en = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic gate_hi;
    logic gate_lo;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbg_phase_ctl #(.DEAD_CYC(DT), .SYNC_STAGES(2)) i_hbg_phase_ctl (
        .clk     (clk),
        .rst     (rst),
        .drv_en  (drv_en),
        .hi_cmd  (hi_cmd),
        .lo_cmd_n(lo_cmd_n),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    // Reference model built from the requirements
    logic [2:0] p1, p2;
    logic       m_hi, m_lo;
    logic       e_b, h_b, ln_b;
    int         quiet;
    string      m_tag;

    always @(posedge clk) begin
        if (rst) begin
            p1 = 3'b001; p2 = 3'b001;
            m_hi = 1'b0; m_lo = 1'b0; quiet = 0; m_tag = "R1";
        end else begin
            e_b = p2[2]; h_b = p2[1]; ln_b = p2[0];
            if (!e_b) begin
                m_hi = 1'b0; m_lo = 1'b0; quiet = 0; m_tag = "R3";
            end else if (h_b && !ln_b) begin
                m_hi = 1'b0; m_lo = 1'b0; quiet = 0; m_tag = "R4";
            end else if (!h_b && ln_b) begin
                if (m_hi || m_lo) quiet = 0;
                else if (quiet < DT) quiet++;
                m_hi = 1'b0; m_lo = 1'b0; m_tag = "R5";
            end else if (h_b) begin
                if (m_lo) begin m_lo = 1'b0; quiet = 0; m_tag = "R8"; end
                else if (m_hi) m_tag = "R11";
                else if (quiet >= DT - 1) begin m_hi = 1'b1; m_tag = "R6"; end
                else begin quiet++; m_tag = "R8"; end
            end else begin
                if (m_hi) begin m_hi = 1'b0; quiet = 0; m_tag = "R8"; end
                else if (m_lo) m_tag = "R11";
                else if (quiet >= DT - 1) begin m_lo = 1'b1; m_tag = "R6"; end
                else begin quiet++; m_tag = "R8"; end
            end
            p2 = p1;
            p1 = {drv_en, hi_cmd, lo_cmd_n};
        end
    end

    task automatic tick();
        @(negedge clk);
        n_vec++;
        if (gate_hi !== m_hi || gate_lo !== m_lo) begin
            n_bad++;
            $display("FAIL %s: gate_hi,gate_lo=%b%b expected %b%b at %0t",
                     m_tag, gate_hi, gate_lo, m_hi, m_lo, $time);
        end
        if (gate_hi && gate_lo) begin
            n_bad++;
            $display("FAIL R7: both gates high, actual 11 expected not 11 at %0t", $time);
        end
    endtask

    task automatic apply(input logic [2:0] c);
        {drv_en, hi_cmd, lo_cmd_n} = c;
    endtask

    // Apply a code and count edges until the chosen output reaches a level
    task automatic measure(input logic [2:0] c, input bit sel_hi, input logic lvl,
                           input int exp, input string tag);
        int lat = -1;
        apply(c);
        for (int k = 1; k <= 3 * DT + 12; k++) begin
            tick();
            if (lat < 0 && ((sel_hi ? gate_hi : gate_lo) === lvl)) lat = k;
        end
        n_vec++;
        if (lat != exp) begin
            n_bad++;
            $display("FAIL %s: latency actual %0d expected %0d (code %b)", tag, lat, exp, c);
        end
    endtask

    task automatic settle(input logic [2:0] c);
        apply(c);
        repeat (SETTLE) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        apply(C_HIGH);
        // R1: outputs low in reset even with a drive request present
        for (int i = 0; i < 4; i++) begin
            tick();
            n_vec++;
            if (gate_hi !== 1'b0 || gate_lo !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: in reset actual %b%b expected 00", gate_hi, gate_lo);
            end
        end
        rst = 1'b0;
        // R1: first rise after release needs a full dead time
        measure(C_HIGH, 1'b1, 1'b1, DT + 2, "R1");

        // R2, R10: long idle then a request passes with pipeline latency only
        settle(C_IDLE);
        measure(C_HIGH, 1'b1, 1'b1, 3, "R2");
        settle(C_IDLE);
        measure(C_LOW, 1'b0, 1'b1, 3, "R10");

        // R3, R4, R5: turn-off latency for each off request
        settle(C_HIGH);
        measure(C_SHUT, 1'b1, 1'b0, 3, "R3");
        settle(C_LOW);
        measure(C_CLASH, 1'b0, 1'b0, 3, "R4");
        settle(C_HIGH);
        measure(C_IDLE, 1'b1, 1'b0, 3, "R5");

        // R8, R10: gap sweep from release to opposite request, both directions
        for (int g = 0; g <= DT + 3; g++) begin
            int exp_lat;
            exp_lat = (DT + 3 - g > 3) ? DT + 3 - g : 3;
            settle(C_IDLE);
            settle(C_HIGH);
            apply(C_IDLE);
            repeat (g) tick();
            measure(C_LOW, 1'b0, 1'b1, exp_lat, (g > DT) ? "R10" : "R8");
            settle(C_LOW);
            apply(C_IDLE);
            repeat (g) tick();
            measure(C_HIGH, 1'b1, 1'b1, exp_lat, (g > DT) ? "R10" : "R8");
        end

        // R9: clash and shutdown windows restart the dead time
        for (int c = 1; c <= DT + 2; c++) begin
            settle(C_HIGH);
            apply(C_CLASH);
            repeat (c) tick();
            measure(C_LOW, 1'b0, 1'b1, DT + 2, "R9");
            apply(C_SHUT);
            repeat (c) tick();
            measure(C_HIGH, 1'b1, 1'b1, DT + 2, "R9");
        end

        // R6, R7, R11: all ordered pairs of codes, compared every cycle
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                apply(3'(a));
                repeat (DT + 4) tick();
                apply(3'(b));
                repeat (DT + 4) tick();
            end
        end

        // Pseudo-random stream with short holds
        lf = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply(lf[2:0]);
            repeat (1 + int'(lf[5:3])) tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule